// File: doc/BRIEF.md
# Fractional Stage-Delay Dither Sequencer

This block lets a ring oscillator behave as if it ran at a non-integer number of stage delays. For each oscillator cycle it picks one of two adjacent odd stage counts. The slower clock edges then average out to the fractional period that was asked for. The block reads an 8-bit trim word. The top three bits choose a nominal stage count of 17 + 2·sel, so the count runs from 17 to 31 in steps of two. The low five bits are a fraction f: in every frame of 32 cycles, exactly f cycles use the longer setting, which is the nominal count plus two.

The long cycles are not bunched together. A 5-bit phase accumulator adds f on every cycle, and a carry out of it marks a long cycle, so the long cycles are spread evenly across the frame. The trim word is taken only on the first cycle of a frame, so every frame runs on one consistent setting. The block registers both the stage count it selects and a flag that marks the start of each frame. The delay line is driven from these outputs, and the control loop that updates the trim word can use the flag to line its updates up with frame boundaries.

Top module: `stage_dither_seq`

## Requirements
- R1: The nominal stage count is 17 + 2·trim_i[7:5], covering 17 (code 000) up to 31 (code 111).
- R2: stages_o only ever holds the frame's nominal count or the nominal count plus two, so its value is odd and lies between 17 and 33.
- R3: A frame lasts 32 cycles. frame_o is high for the first cycle of each frame and low for the other 31.
- R4: Within each frame, the number of cycles whose output is the longer count equals the fraction trim_i[4:0] taken at that frame's start.
- R5: A fraction of 0 gives no long cycles in the frame. A fraction of 31 gives 31 long cycles and exactly one nominal cycle.
- R6: Cycle k of a frame (k = 0..31) is long exactly when floor((k+1)·f/32) > floor(k·f/32).
- R7: trim_i is sampled only on the first cycle of a frame. A change made in the middle of a frame has no effect until the next frame starts.
- R8: While rst_ni is low, frame_o is 0 and stages_o is 17. The first cycle after reset is released begins a frame.
- R9: Both outputs are registered. The selection for a cycle appears on the output one clock edge after that cycle is processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-cycle clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trim_i | input | 8 | Stage trim word: [7:5] coarse select, [4:0] fraction |
| stages_o | output | 6 | Stage count to apply this cycle (17..33) |
| frame_o | output | 1 | High on the first cycle of each 32-cycle frame |

## Verification
The sequence is driven with the fraction at 0 and at 31, at 1 and 16, and at odd values such as 5 and 13, and with a range of coarse codes. The fractions 0 and 31 show whether the extreme counts come out right. The fractions 1 and 16 show where long cycles land in the frame and whether they are spread out or bunched. The odd fractions show whether the accumulator carries at the positions given by the floor formula. The trim word is also changed in the middle of a frame, which shows whether the sequencer samples it only at the frame boundary. A reference model in the bench counts the long cycles in each frame and checks the position of every long cycle.

// File: rtl/stage_dither_pkg.sv
package stage_dither_pkg;
  localparam int unsigned DITH_FRAC_W   = 5;
  localparam int unsigned DITH_SEL_W    = 3;
  localparam int unsigned DITH_BASE     = 17;
  localparam int unsigned DITH_STEP     = 2;

  function automatic int unsigned max_stages(input int unsigned base, input int unsigned sel_w);
    return base + DITH_STEP * ((1 << sel_w) - 1) + DITH_STEP;
  endfunction
endpackage

// File: rtl/dither_frame_ctr.sv
module dither_frame_ctr #(
  parameter int unsigned FRAC_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              first_o,
  output logic              last_o
);
  localparam logic [FRAC_W-1:0] CNT_MAX = {FRAC_W{1'b1}};

  logic [FRAC_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign first_o = (cnt_q == '0);
  assign last_o  = (cnt_q == CNT_MAX);

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> (cnt_q == $past(cnt_q) + 1'b1)); // R3
endmodule

// File: rtl/dither_phase_acc.sv
module dither_phase_acc #(
  parameter int unsigned FRAC_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              last_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              carry_o
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  // frame start reseeds the phase so each frame yields exactly frac carries
  always_comb sum = {1'b0, (restart_i ? '0 : acc_q)} + {1'b0, frac_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= sum[FRAC_W-1:0];
  end

  assign carry_o = sum[FRAC_W];

  AST_ACC_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_i |=> (acc_q == '0)); // R4
endmodule

// File: rtl/dither_stage_enc.sv
module dither_stage_enc #(
  parameter int unsigned SEL_W = 3,
  parameter int unsigned BASE  = 17,
  parameter int unsigned STEP  = 2,
  parameter int unsigned STG_W = 6
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             long_i,
  output logic [STG_W-1:0] stages_o
);
  localparam int unsigned N_SEL = 1 << SEL_W;

  logic [STG_W-1:0] nom_tab [N_SEL];

  for (genvar g = 0; g < N_SEL; g++) begin : g_nom
    assign nom_tab[g] = STG_W'(BASE + STEP * g);
  end

  assign stages_o = nom_tab[sel_i] + (long_i ? STG_W'(STEP) : '0);
endmodule

// File: rtl/stage_dither_seq.sv
module stage_dither_seq
  import stage_dither_pkg::*;
#(
  parameter int unsigned FRAC_W = DITH_FRAC_W,
  parameter int unsigned SEL_W  = DITH_SEL_W,
  parameter int unsigned BASE   = DITH_BASE,
  localparam int unsigned TRIM_W = FRAC_W + SEL_W,
  localparam int unsigned STG_W  = $clog2(max_stages(BASE, SEL_W) + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TRIM_W-1:0] trim_i,
  output logic [STG_W-1:0]  stages_o,
  output logic              frame_o
);
  localparam int unsigned MAX_ST = max_stages(BASE, SEL_W);

  logic              first, last, carry;
  logic [SEL_W-1:0]  sel_q, sel_eff;
  logic [FRAC_W-1:0] frac_q, frac_eff;
  logic [STG_W-1:0]  stages_d;

  dither_frame_ctr #(.FRAC_W(FRAC_W)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .first_o(first), .last_o(last)
  );

  // trim is honoured only at frame start
  assign sel_eff  = first ? trim_i[TRIM_W-1:FRAC_W] : sel_q;
  assign frac_eff = first ? trim_i[FRAC_W-1:0]      : frac_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      frac_q <= '0;
    end else if (first) begin
      sel_q  <= trim_i[TRIM_W-1:FRAC_W];
      frac_q <= trim_i[FRAC_W-1:0];
    end
  end

  dither_phase_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(first), .last_i(last),
    .frac_i(frac_eff), .carry_o(carry)
  );

  dither_stage_enc #(.SEL_W(SEL_W), .BASE(BASE), .STEP(DITH_STEP), .STG_W(STG_W)) u_enc (
    .sel_i(sel_eff), .long_i(carry), .stages_o(stages_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stages_o <= STG_W'(BASE);
      frame_o  <= 1'b0;
    end else begin
      stages_o <= stages_d;
      frame_o  <= first;
    end
  end

  AST_STAGE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stages_o >= STG_W'(BASE)) && (stages_o <= STG_W'(MAX_ST))); // R1
  AST_STAGE_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stages_o[0]); // R2
  AST_FRAME_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |=> !frame_o); // R3
  AST_TRIM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !first |=> $stable({sel_q, frac_q})); // R7
endmodule

// File: tb/tb_stage_dither_seq.sv
module tb_stage_dither_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] trim_i = 8'h00;
  logic [5:0] stages_o;
  logic       frame_o;

  int n_chk = 0, n_fail = 0;
  int k = 0, mf = 0, ms = 0, obs_long = 0, frames = 0;
  int exp_stage = 17, exp_nom = 17;
  bit exp_frame = 1'b0, valid = 1'b0, frame_done = 1'b0;
  int done_f = 0, done_long = 0;

  stage_dither_seq dut (.clk_i(clk_i), .rst_ni(rst_ni), .trim_i(trim_i),
                        .stages_o(stages_o), .frame_o(frame_o));

  always #4 clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      k = 0; valid = 1'b0;
    end else begin
      if (k == 0) begin
        mf = trim_i[4:0];
        ms = trim_i[7:5];
      end
      exp_nom   = 17 + 2 * ms;
      exp_stage = exp_nom + ((((k + 1) * mf) / 32 != (k * mf) / 32) ? 2 : 0);
      exp_frame = (k == 0);
      k = (k + 1) % 32;
      valid = 1'b1;
    end
  end

  always @(negedge clk_i) begin
    if (valid) begin
      check(stages_o == exp_stage, "R1 R2 R6 R7 R9 stage", stages_o, exp_stage);
      check(frame_o == exp_frame, "R3 frame flag", frame_o, exp_frame);
      if (frame_o) obs_long = 0;
      if (stages_o == exp_nom + 2) obs_long++;
      if (k == 0) begin
        check(obs_long == mf, (mf == 0 || mf == 31) ? "R5 long count" : "R4 long count",
              obs_long, mf);
        frames++;
      end
    end
  end

  task automatic run_frames(input logic [7:0] t, input int n);
    trim_i = t;
    repeat (32 * n) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(stages_o == 17, "R8 reset stage", stages_o, 17);
    check(frame_o == 1'b0, "R8 reset frame", frame_o, 0);
    trim_i = {3'b011, 5'd0};
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(frame_o == 1'b1, "R8 first frame after reset", frame_o, 1);
    repeat (31) @(negedge clk_i);
    run_frames({3'b011, 5'd31}, 2);
    run_frames({3'b000, 5'd1}, 1);
    run_frames({3'b111, 5'd16}, 1);
    run_frames({3'b111, 5'd31}, 1);
    run_frames({3'b010, 5'd5}, 2);
    run_frames({3'b101, 5'd13}, 1);
    // mid-frame change must wait for the next frame (R7)
    repeat (10) @(negedge clk_i);
    trim_i = {3'b110, 5'd29};
    repeat (22) @(negedge clk_i);
    run_frames({3'b001, 5'd7}, 1);
    repeat (5) @(negedge clk_i);
    trim_i = {3'b100, 5'd0};
    repeat (27 + 64) @(negedge clk_i);
    check(frames >= 12, "R3 frame count", frames, 12);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule